// File: doc/BRIEF.md
# Associative SIMD Processing Element Array

This block is a line of simple processing elements (PEs). Each PE holds one word of content-addressable storage and a one-bit tag. A single command stream is broadcast to every PE at once. A masked search compares a key against all stored words in one cycle. The outcomes stay inside the PEs as tags, and the tags can then be combined with the results of later searches, set, cleared or inverted. They also decide which PEs a conditional write or a masked XOR changes.

The tags also form a one-bit shift chain along the line, with a serial link port at each end. This lets a controller walk a single tag to any PE so that word can be loaded. It also lets tag patterns move between neighbours. A readout command returns the tagged words one at a time, lowest PE index first, and clears each tag as its word is delivered.

Commands enter on a valid/ready port. A command is accepted on a rising edge where `cmd_valid` and `cmd_ready` are both high. `cmd_ready` is low while a readout result is waiting, so at most one result is ever pending. The result port is also valid/ready. A result stays on the port, unchanged, until the consumer takes it with `res_ready`.

Top module: `assoc_array`

## Requirements
- R1: After reset, all tags and stored words are zero, `res_valid` is low, `none_left` is high and `cmd_ready` is high.
- R2: Opcode 1 (search) sets the tag of every PE to 1 when `((word ^ key) & mask) == 0`, and to 0 otherwise. All PEs update on the edge that accepts the command. A mask of zero matches every PE.
- R3: Opcode 2 ANDs the search result into the existing tags. Opcode 3 ORs it into them.
- R4: Opcode 4 sets every tag, opcode 5 clears every tag and opcode 6 inverts every tag.
- R5: Opcode 7 replaces the masked bits of the word in every tagged PE with the key bits. Unmasked bits and untagged PEs are left unchanged.
- R6: Opcode 8 XORs `key & mask` into the word of every tagged PE. Untagged PEs are left unchanged.
- R7: Opcode 9 shifts the tags toward higher indices. PE 0 takes `left_in`. `right_out` always shows the tag of the last PE.
- R8: Opcode 10 shifts the tags toward lower indices. The last PE takes `right_in`. `left_out` always shows the tag of PE 0.
- R9: When any tag is set, opcode 11 (read) produces a result with `res_found`=1. The result carries the word and index of the lowest-indexed tagged PE, and that PE's tag is cleared.
- R10: When no tag is set, opcode 11 produces a result with `res_found`=0, and the tags are left unchanged.
- R11: `none_left` is high exactly when no tag is set. `tag_vec` bit i is the tag of PE i.
- R12: `cmd_ready` is low while `res_valid` is high. A result that is not taken holds its word and index stable.
- R13: Opcode 0 and opcodes 12 to 15 change neither tags nor words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | A command is offered |
| cmd_ready | output | 1 | The array can accept a command |
| cmd_op | input | 4 | Opcode |
| cmd_key | input | W | Search key, or the data to write or XOR |
| cmd_mask | input | W | Bit positions that take part |
| left_in | input | 1 | Serial bit entering PE 0 on a shift toward higher indices |
| left_out | output | 1 | Tag of PE 0 |
| right_in | input | 1 | Serial bit entering the last PE on a shift toward lower indices |
| right_out | output | 1 | Tag of the last PE |
| res_valid | output | 1 | A readout result is present |
| res_ready | input | 1 | The consumer takes the result |
| res_word | output | W | Word read out |
| res_index | output | IW | Index of the PE read out |
| res_found | output | 1 | The read found a tagged PE |
| tag_vec | output | N | Current tags |
| none_left | output | 1 | No tag is set |

## Verification
The bench covers several corner cases:

- A fully masked-off search must tag every PE. An inverted comparison or mask would tag none.
- Readout must run strictly lowest index first and clear exactly one tag per read. A wrong priority direction shows up as an out-of-order index, and a missing clear repeats the same word.
- A read on an empty tag set must report not-found and leave the tags alone.
- Writes and XORs are checked by reading back the whole array afterwards. Any leak into untagged PEs or unmasked bits changes a returned word.
- The bench holds off `res_ready` for several cycles. A design that drops or overwrites a pending result loses an expected item.
- Shifts are run with a one entering at each end. A swapped direction or a swapped link port shows up at once in `tag_vec` and in the outgoing port.

// File: rtl/assoc_pkg.sv
package assoc_pkg;
  typedef enum logic [3:0] {
    OP_NOP      = 4'd0,
    OP_SRCH     = 4'd1,
    OP_SRCH_AND = 4'd2,
    OP_SRCH_OR  = 4'd3,
    OP_TSET     = 4'd4,
    OP_TCLR     = 4'd5,
    OP_TINV     = 4'd6,
    OP_WR       = 4'd7,
    OP_XOR      = 4'd8,
    OP_SHR      = 4'd9,
    OP_SHL      = 4'd10,
    OP_READ     = 4'd11
  } op_e;
endpackage

// File: rtl/assoc_pe.sv
module assoc_pe
  import assoc_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         exec,
  input  op_e          op,
  input  logic [W-1:0] key,
  input  logic [W-1:0] mask,
  input  logic         nbr_lo,
  input  logic         nbr_hi,
  input  logic         take,
  output logic [W-1:0] word,
  output logic         tag
);
  logic hit;
  assign hit = ((word ^ key) & mask) == '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      word <= '0;
      tag  <= 1'b0;
    end else if (exec) begin
      case (op)
        OP_SRCH:     tag <= hit;
        OP_SRCH_AND: tag <= tag & hit;
        OP_SRCH_OR:  tag <= tag | hit;
        OP_TSET:     tag <= 1'b1;
        OP_TCLR:     tag <= 1'b0;
        OP_TINV:     tag <= ~tag;
        OP_WR:       if (tag) word <= (word & ~mask) | (key & mask);
        OP_XOR:      if (tag) word <= word ^ (key & mask);
        OP_SHR:      tag <= nbr_lo;
        OP_SHL:      tag <= nbr_hi;
        OP_READ:     if (take) tag <= 1'b0;
        default:     ;
      endcase
    end
  end

  // R5
  wr_tag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (exec && op == OP_WR && tag) |=> ((word & $past(mask)) == ($past(key) & $past(mask))));
  // R5
  wr_untag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (exec && op == OP_WR && !tag) |=> $stable(word));
  // R4
  tset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (exec && op == OP_TSET) |=> tag);
endmodule

// File: rtl/assoc_prio.sv
module assoc_prio #(
  parameter int N  = 16,
  parameter int IW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [N-1:0]  req,
  output logic [N-1:0]  grant,
  output logic [IW-1:0] idx,
  output logic          any
);
  always_comb begin
    grant = '0;
    idx   = '0;
    any   = 1'b0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) begin
        grant = '0;
        grant[i] = 1'b1;
        idx = IW'(i);
        any = 1'b1;
      end
    end
  end

  // R9
  grant_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant) && ((grant & ~req) == '0));
endmodule

// File: rtl/assoc_array.sv
module assoc_array
  import assoc_pkg::*;
#(
  parameter int N  = 16,
  parameter int W  = 32,
  parameter int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_valid,
  output logic          cmd_ready,
  input  logic [3:0]    cmd_op,
  input  logic [W-1:0]  cmd_key,
  input  logic [W-1:0]  cmd_mask,
  input  logic          left_in,
  output logic          left_out,
  input  logic          right_in,
  output logic          right_out,
  output logic          res_valid,
  input  logic          res_ready,
  output logic [W-1:0]  res_word,
  output logic [IW-1:0] res_index,
  output logic          res_found,
  output logic [N-1:0]  tag_vec,
  output logic          none_left
);
  op_e           op;
  logic          exec;
  logic [W-1:0]  words [N];
  logic [N-1:0]  grant;
  logic [IW-1:0] gidx;
  logic          gany;
  logic [W-1:0]  sel_word;

  assign op        = op_e'(cmd_op);
  assign cmd_ready = !res_valid;
  assign exec      = cmd_valid && cmd_ready;

  for (genvar i = 0; i < N; i++) begin : g_pe
    logic lo, hi;
    if (i == 0) begin : g_lo_end
      assign lo = left_in;
    end else begin : g_lo_mid
      assign lo = tag_vec[i-1];
    end
    if (i == N - 1) begin : g_hi_end
      assign hi = right_in;
    end else begin : g_hi_mid
      assign hi = tag_vec[i+1];
    end
    assoc_pe #(.W(W)) u_pe (
      .clk(clk), .rst_n(rst_n), .exec(exec), .op(op),
      .key(cmd_key), .mask(cmd_mask), .nbr_lo(lo), .nbr_hi(hi),
      .take(grant[i]), .word(words[i]), .tag(tag_vec[i])
    );
  end

  assoc_prio #(.N(N), .IW(IW)) u_prio (
    .clk(clk), .rst_n(rst_n), .req(tag_vec),
    .grant(grant), .idx(gidx), .any(gany)
  );

  always_comb begin
    sel_word = '0;
    for (int i = 0; i < N; i++) sel_word |= words[i] & {W{grant[i]}};
  end

  assign left_out  = tag_vec[0];
  assign right_out = tag_vec[N-1];
  assign none_left = ~|tag_vec;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      res_valid <= 1'b0;
      res_word  <= '0;
      res_index <= '0;
      res_found <= 1'b0;
    end else if (exec && op == OP_READ) begin
      res_valid <= 1'b1;
      res_word  <= sel_word;
      res_index <= gidx;
      res_found <= gany;
    end else if (res_valid && res_ready) begin
      res_valid <= 1'b0;
    end
  end

  // R9
  read_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (exec && op == OP_READ && tag_vec != '0) |=>
      ($countones(tag_vec) == $countones($past(tag_vec)) - 1) && res_found);
  // R10
  read_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (exec && op == OP_READ && tag_vec == '0) |=> (res_valid && !res_found && tag_vec == '0));
  // R12
  res_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_ready) |=> (res_valid && $stable(res_word) && $stable(res_index)));
  // R13
  nop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (exec && cmd_op inside {4'd0, [4'd12:4'd15]}) |=> $stable(tag_vec));
endmodule

// File: tb/assoc_array_tb.sv
module assoc_array_tb;
  localparam int N = 16;
  localparam int W = 32;
  localparam int IW = 4;

  logic clk = 0, rst_n = 0;
  logic cmd_valid = 0, cmd_ready;
  logic [3:0] cmd_op = 0;
  logic [W-1:0] cmd_key = 0, cmd_mask = 0;
  logic left_in = 0, left_out, right_in = 0, right_out;
  logic res_valid, res_ready = 0, res_found, none_left;
  logic [W-1:0] res_word;
  logic [IW-1:0] res_index;
  logic [N-1:0] tag_vec;

  int n_chk = 0, n_fail = 0;
  logic [W-1:0] m_word [N];
  logic [N-1:0] m_tag;
  logic [W+IW:0] exp_q [$];
  string rq_q [$];
  bit done = 0;

  always #10 clk = ~clk;

  assoc_array #(.N(N), .W(W)) u_dut (.*);

  task automatic chk(input bit ok, input string r, input logic [63:0] act, exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", r, act, exp);
    end
  endtask

  function automatic logic [W-1:0] wv(input int i);
    return {8'hC0 + 8'(i % 3), 8'h5A, 8'(i * 7), 8'(i)};
  endfunction

  task automatic issue(input logic [3:0] op, input logic [W-1:0] k = 0,
                       input logic [W-1:0] m = 0, input logic li = 0,
                       input logic ri = 0, input string why = "R9");
    logic [N-1:0] nt;
    string r;
    while (!cmd_ready) @(negedge clk);
    cmd_valid = 1; cmd_op = op; cmd_key = k; cmd_mask = m;
    left_in = li; right_in = ri;
    nt = m_tag;
    for (int i = 0; i < N; i++) begin
      bit hit;
      hit = ((m_word[i] ^ k) & m) == 0;
      case (op)
        1: nt[i] = hit;
        2: nt[i] = m_tag[i] & hit;
        3: nt[i] = m_tag[i] | hit;
        4: nt[i] = 1;
        5: nt[i] = 0;
        6: nt[i] = ~m_tag[i];
        7: if (m_tag[i]) m_word[i] = (m_word[i] & ~m) | (k & m);
        8: if (m_tag[i]) m_word[i] = m_word[i] ^ (k & m);
        9: nt[i] = (i == 0) ? li : m_tag[i-1];
        10: nt[i] = (i == N - 1) ? ri : m_tag[i+1];
        default: ;
      endcase
    end
    if (op == 11) begin
      logic [W+IW:0] e;
      e = '0;
      for (int i = N - 1; i >= 0; i--)
        if (m_tag[i]) e = {1'b1, IW'(i), m_word[i]};
      if (e[W+IW]) nt[e[W+IW-1:W]] = 0;
      exp_q.push_back(e);
      rq_q.push_back(e[W+IW] ? why : "R10");
    end
    m_tag = nt;
    @(posedge clk); #1 cmd_valid = 0;
    @(negedge clk);
    case (op)
      1: r = "R2"; 2, 3: r = "R3"; 4, 5, 6: r = "R4"; 7: r = "R5";
      8: r = "R6"; 9: r = "R7"; 10: r = "R8"; 11: r = "R9";
      default: r = "R13";
    endcase
    chk(tag_vec == m_tag, r, tag_vec, m_tag);
    chk(none_left == (m_tag == 0), "R11", none_left, m_tag == 0);
    if (op == 9) chk(right_out == m_tag[N-1], "R7", right_out, m_tag[N-1]);
    if (op == 10) chk(left_out == m_tag[0], "R8", left_out, m_tag[0]);
  endtask

  task automatic read_all(input string why);
    while (m_tag != 0) issue(11, 0, 0, 0, 0, why);
  endtask

  // result stall pattern
  initial begin
    int c = 0;
    forever begin
      @(posedge clk); #2;
      c++;
      res_ready = (c % 3) == 0;
    end
  end

  // monitor
  initial begin
    forever begin
      @(negedge clk);
      if (res_valid && !res_ready) chk(cmd_ready == 0, "R12", cmd_ready, 0);
      if (res_valid && res_ready) begin
        if (exp_q.size() == 0) chk(0, "R12", 1, 0);
        else begin
          logic [W+IW:0] e;
          string r;
          e = exp_q.pop_front();
          r = rq_q.pop_front();
          chk(res_found == e[W+IW], r, res_found, e[W+IW]);
          if (e[W+IW]) begin
            chk(res_index == e[W+IW-1:W], r, res_index, e[W+IW-1:W]);
            chk(res_word == e[W-1:0], r, res_word, e[W-1:0]);
          end
        end
      end
    end
  end

  // watchdog
  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    m_tag = 0;
    for (int i = 0; i < N; i++) m_word[i] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1
    chk(tag_vec == 0, "R1", tag_vec, 0);
    chk(none_left == 1, "R1", none_left, 1);
    chk(res_valid == 0, "R1", res_valid, 0);
    chk(cmd_ready == 1, "R1", cmd_ready, 1);
    issue(11);                                   // R10 on empty array
    // load words by walking one tag along the chain (R7, R5)
    for (int i = 0; i < N; i++) begin
      issue(5);
      issue(9, 0, 0, 1);
      repeat (i) issue(9, 0, 0, 0);
      issue(7, wv(i), '1);
    end
    issue(4); read_all("R5");                    // R9 order, R5 load
    issue(1, wv(5), '1);                         // R2 exact
    issue(1, 32'hC100_0000, 32'hFF00_0000);      // R2 masked
    issue(2, 32'h1, 32'h1);                      // R3 and
    issue(3, wv(2), '1);                         // R3 or
    read_all("R9");
    issue(11);                                   // R10
    issue(4); issue(6); issue(6);                // R4
    issue(5); issue(1, 32'h1234_5678, 0);        // R2 mask zero
    issue(1, 32'hC200_0000, 32'hFF00_0000);
    issue(7, 32'h0000_00EE, 32'h0000_00FF);      // R5 masked write
    issue(4); read_all("R5");
    issue(1, 32'hC000_0000, 32'hFF00_0000);
    issue(8, 32'h0000_0F0F, 32'h0000_FF00);      // R6
    issue(13, 32'hFFFF_FFFF, '1);                // R13
    issue(0);
    issue(4); read_all("R6");
    issue(5);
    issue(10, 0, 0, 0, 1); issue(10, 0, 0, 0, 1);// R8
    for (int i = 0; i < N; i++) issue(10);
    issue(9, 0, 0, 1); issue(4);
    issue(15, 32'hFFFF_FFFF, '1);                // R13
    read_all("R13");
    while (exp_q.size() != 0) @(negedge clk);
    repeat (2) @(negedge clk);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule